// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared PCI interrupt request lines (A, B, C and D) onto the sixteen inputs of a legacy interrupt controller. Each request line has its own one-byte route register. System software sets these registers through a config-space write port. A route value selects which controller input the line drives, or leaves the line unconnected. When several request lines select the same controller input, their levels are merged with a logical OR.

The sixteen outputs are combinational functions of the route registers and the current request levels. A level change therefore shows on the outputs in the same cycle. A route change shows in the cycle after the write edge. The block also contains a stand-alone helper that works out which request line a device interrupt pin uses, based on the device's slot number. Request levels and the helper inputs are plain level signals, so the block has no back-pressure anywhere. The write port is a single-cycle strobe that is always accepted.

Top module: `irq_line_router`

## Requirements
- R1: After a synchronous active-high reset, all four route registers hold 0x80, so every request line is unrouted and all sixteen outputs are low whatever the request levels are.
- R2: When the route register of a line holds a value v in 0 to 15, output bit v follows the level of that line. The value 15 drives output bit 15.
- R3: A route value of 16 or more (for example 0x10, 0x80 or 0xFF) disconnects the line, so it drives no output.
- R4: An output that two or more lines select is the OR of their levels. It stays high while any one of them is high.
- R5: After a route register is rewritten, the output the line used to drive drops and the newly selected output follows the line. Both changes are visible in the cycle after the write edge.
- R6: A write updates only the byte lanes whose enable bit is set. Lane k of the 32-bit data (bits 8k+7 down to 8k) goes to byte address {cfg_addr[7:2], k}. The route registers of lines A, B, C and D sit at byte addresses 0x60, 0x61, 0x62 and 0x63.
- R7: Writes whose dword address (cfg_addr[7:2]) differs from that of 0x60 to 0x63 leave all route registers unchanged.
- R8: The swizzle helper returns line (pin + slot − 1) mod 4, where slot = devfn[7:3] and the pin is numbered 0 to 3 for A to D. Slot 0 therefore maps pin 0 to line 3.
- R9: A change in the request levels reaches the outputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Config write strobe, one cycle per write |
| cfg_addr | input | 8 | Config byte address. Bits 1:0 are ignored and lanes pick the byte. |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| req_level | input | 4 | Request line levels, bit 0 = line A |
| irq_out | output | 16 | Controller input levels |
| sw_devfn | input | 8 | Device/function number for the swizzle helper |
| sw_pin | input | 2 | Device interrupt pin, 0 = A |
| sw_line | output | 2 | Request line index for that pin |

## Verification
The routing function is exercised with the following patterns:
- a one-to-one map with several level patterns, which separates per-line steering from shared merging;
- two lines routed to the same output and released one at a time, which shows OR merging rather than last-writer wins;
- boundary route values 15, 16 and 0xFF, which locate the disable threshold;
- moving a line that is asserted, which shows that the old output is released and not left stuck.

Masked-lane writes and off-window writes are followed at once by level patterns that would reveal any corrupted route. Swizzle cases cover slot 0, slot 1, a function number in the low bits and the highest slot, which separates the rotation from plain pass-through.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned LINES_DEF  = 4;
  localparam int unsigned INPUTS_DEF = 16;
  localparam int unsigned ROUTE_BITS = 8;
  localparam int unsigned ROUTE_BASE = 8'h60;
  localparam logic [ROUTE_BITS-1:0] ROUTE_OFF = 8'h80;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_LINES = LINES_DEF,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_ADDR = ROUTE_BASE,
  parameter logic [ROUTE_BITS-1:0] RESET_ROUTE = ROUTE_OFF
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W/8-1:0]                   be,
  input  logic [DATA_W-1:0]                     wdata,
  output logic [NUM_LINES-1:0][ROUTE_BITS-1:0]  route_q
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(BASE_ADDR + NUM_LINES - 1);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [ADDR_W-1:0] TGT = ADDR_W'(BASE_ADDR + i);
    localparam int unsigned LANE = (BASE_ADDR + i) % LANES;
    logic hit;
    assign hit = wr_en && be[LANE] &&
                 (addr[ADDR_W-1:LANE_W] == TGT[ADDR_W-1:LANE_W]);

    always_ff @(posedge clk) begin
      if (rst)      route_q[i] <= RESET_ROUTE;
      else if (hit) route_q[i] <= wdata[LANE*8 +: ROUTE_BITS];
    end

    // R6: a disabled lane never changes its register
    a_r6_lane_masked: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !be[LANE]) |=> $stable(route_q[i]));
  end

  // R7: writes outside the route dword window leave every route unchanged
  a_r7_off_window: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ((addr[ADDR_W-1:LANE_W] < FIRST[ADDR_W-1:LANE_W]) ||
               (addr[ADDR_W-1:LANE_W] > LAST[ADDR_W-1:LANE_W])))
    |=> $stable(route_q));
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_LINES  = LINES_DEF,
  parameter int unsigned NUM_INPUTS = INPUTS_DEF
) (
  input  logic [NUM_LINES-1:0][ROUTE_BITS-1:0] route,
  input  logic [NUM_LINES-1:0]                 level,
  output logic [NUM_INPUTS-1:0]                out
);
  for (genvar j = 0; j < NUM_INPUTS; j++) begin : g_in
    logic [NUM_LINES-1:0] sel;
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
      assign sel[i] = level[i] && (route[i] == ROUTE_BITS'(j));
    end
    assign out[j] = |sel;
  end
endmodule

// File: rtl/irq_slot_swizzle.sv
module irq_slot_swizzle
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_LINES = LINES_DEF,
  parameter int unsigned DEVFN_W   = 8,
  parameter int unsigned FUNC_BITS = 3
) (
  input  logic [DEVFN_W-1:0]           devfn,
  input  logic [$clog2(NUM_LINES)-1:0] pin,
  output logic [$clog2(NUM_LINES)-1:0] line
);
  localparam int unsigned LINE_W = $clog2(NUM_LINES);
  logic [DEVFN_W-FUNC_BITS-1:0] slot;
  logic [LINE_W-1:0]            slot_lo;

  assign slot    = devfn[DEVFN_W-1:FUNC_BITS];
  assign slot_lo = slot[LINE_W-1:0];
  assign line    = pin + slot_lo - LINE_W'(1);
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_LINES  = LINES_DEF,
  parameter int unsigned NUM_INPUTS = INPUTS_DEF,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BASE_ADDR  = ROUTE_BASE,
  parameter int unsigned DEVFN_W    = 8,
  parameter int unsigned FUNC_BITS  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_wr_en,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [DATA_W/8-1:0]           cfg_be,
  input  logic [DATA_W-1:0]             cfg_wdata,
  input  logic [NUM_LINES-1:0]          req_level,
  output logic [NUM_INPUTS-1:0]         irq_out,
  input  logic [DEVFN_W-1:0]            sw_devfn,
  input  logic [$clog2(NUM_LINES)-1:0]  sw_pin,
  output logic [$clog2(NUM_LINES)-1:0]  sw_line
);
  logic [NUM_LINES-1:0][ROUTE_BITS-1:0] route_q;

  irq_route_regs #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BASE_ADDR(BASE_ADDR), .RESET_ROUTE(ROUTE_OFF)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .be(cfg_be), .wdata(cfg_wdata), .route_q(route_q)
  );

  irq_route_merge #(.NUM_LINES(NUM_LINES), .NUM_INPUTS(NUM_INPUTS)) u_merge (
    .route(route_q), .level(req_level), .out(irq_out)
  );

  irq_slot_swizzle #(
    .NUM_LINES(NUM_LINES), .DEVFN_W(DEVFN_W), .FUNC_BITS(FUNC_BITS)
  ) u_swz (
    .devfn(sw_devfn), .pin(sw_pin), .line(sw_line)
  );

  // R2: a routed, asserted line always raises its selected output
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    a_r2_routed_high: assert property (@(posedge clk) disable iff (rst)
      (route_q[i] < ROUTE_BITS'(NUM_INPUTS) && req_level[i])
      |-> irq_out[route_q[i][$clog2(NUM_INPUTS)-1:0]]);
  end

  // R4: merging never raises more outputs than there are active lines
  a_r4_merge_bound: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_out) <= $countones(req_level));

  // R9: no active line means every output is low in the same cycle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_level == '0) |-> (irq_out == '0));

  // R8: slot 1 passes the pin straight through
  a_r8_slot_one: assert property (@(posedge clk) disable iff (rst)
    (sw_devfn[DEVFN_W-1:FUNC_BITS] == 1) |-> (sw_line == sw_pin));
endmodule

// File: tb/irq_line_router_tb.sv
module irq_line_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  req_level = '0;
  logic [15:0] irq_out;
  logic [7:0]  sw_devfn = '0;
  logic [1:0]  sw_pin = '0;
  logic [1:0]  sw_line;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irq_line_router u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .req_level(req_level),
    .irq_out(irq_out), .sw_devfn(sw_devfn), .sw_pin(sw_pin), .sw_line(sw_line)
  );

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb[$];
  logic [7:0] rm [4];

  function automatic logic [15:0] model_out(input logic [3:0] lv);
    logic [15:0] r = '0;
    for (int i = 0; i < 4; i++)
      if (rm[i] < 8'd16 && lv[i]) r[rm[i][3:0]] = 1'b1;
    return r;
  endfunction

  task automatic push(input string tag);
    item_t it;
    it.exp = model_out(req_level);
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    item_t it;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      n_tests++;
      if (irq_out !== it.exp) begin
        n_fail++;
        $display("FAIL %s: irq_out=%h expected %h", it.tag, irq_out, it.exp);
      end
    end
  end

  task automatic set_lv(input logic [3:0] lv, input string tag);
    @(posedge clk); #1;
    req_level = lv;
    push(tag);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [3:0] be,
                          input logic [31:0] d, input string tag);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ba;
      ba = {a[7:2], 2'(k)};
      if (be[k] && ba >= 8'h60 && ba <= 8'h63) rm[ba - 8'h60] = d[8*k +: 8];
    end
    push(tag);
  endtask

  task automatic do_reset(input string tag);
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int i = 0; i < 4; i++) rm[i] = 8'h80;
    push(tag);
  endtask

  task automatic chk_line(input logic [7:0] df, input logic [1:0] p,
                          input logic [1:0] exp, input string tag);
    sw_devfn = df; sw_pin = p;
    #1;
    n_tests++;
    if (sw_line !== exp) begin
      n_fail++;
      $display("FAIL %s: sw_line=%0d expected %0d", tag, sw_line, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) rm[i] = 8'h80;
    req_level = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    push("R1 outputs low in reset");
    @(posedge clk); #1;
    rst = 1'b0;
    push("R1 routes disabled after reset");
    // R2: one-to-one map A->0 B->1 C->2 D->3
    do_write(8'h60, 4'hF, 32'h03020100, "R2 map write");
    set_lv(4'b0101, "R2 lines A,C");
    set_lv(4'b1010, "R9 lines B,D same cycle");
    set_lv(4'b1111, "R2 all lines");
    // R6: only lane 3 enabled, other lanes carry garbage
    do_write(8'h60, 4'b1000, 32'h05EEEEEE, "R6 masked write");
    set_lv(4'b0111, "R6 lanes 0-2 kept");
    set_lv(4'b1000, "R6 line D moved to 5");
    // R4: B also to 5
    do_write(8'h61, 4'b0010, 32'h00000500, "R4 share write");
    set_lv(4'b1010, "R4 both shared high");
    set_lv(4'b0010, "R4 only B high");
    set_lv(4'b1000, "R4 only D high");
    set_lv(4'b0000, "R4 both low");
    // R3 / R2 boundaries on line C
    do_write(8'h62, 4'b0100, 32'h00100000, "R3 route 0x10");
    set_lv(4'b0100, "R3 value 16 disabled");
    do_write(8'h62, 4'b0100, 32'h00FF0000, "R3 route 0xFF");
    do_write(8'h62, 4'b0100, 32'h000F0000, "R2 route 15");
    // R5: move asserted line A from 0 to 9
    set_lv(4'b0001, "R5 before move");
    do_write(8'h60, 4'b0001, 32'h00000009, "R5 after move");
    // R7: off-window writes
    do_write(8'h64, 4'hF, 32'h00000000, "R7 dword 0x64 ignored");
    do_write(8'h5C, 4'hF, 32'h00000000, "R7 dword 0x5C ignored");
    do_write(8'hE0, 4'hF, 32'h00000000, "R7 dword 0xE0 ignored");
    set_lv(4'b1111, "R7 routes intact");
    do_reset("R1 reset mid-run");
    set_lv(4'b1011, "R1 still disabled");
    // R8: swizzle helper
    chk_line(8'h08, 2'd2, 2'd2, "R8 slot 1 pin 2");
    chk_line(8'h00, 2'd0, 2'd3, "R8 slot 0 pin 0");
    chk_line(8'h10, 2'd3, 2'd0, "R8 slot 2 pin 3");
    chk_line(8'h1F, 2'd1, 2'd3, "R8 slot 3 func 7 pin 1");
    chk_line(8'hF8, 2'd0, 2'd2, "R8 slot 31 pin 0");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule